// File: doc/BRIEF.md
# Weak-Ordering Fence Gate

This block sits between an in-order stream of memory requests and a memory system that may finish operations in any order. Each request carries a one-bit class: an ordinary data access or a synchronization access. Data accesses go straight through to memory in the cycle they are offered. Several of them may be in flight at once, and they may return in any order.

A synchronization access acts as a full fence. It is held until every data access issued before it has returned. Once it issues, nothing further is accepted until its own completion has come back. The block counts the data accesses that are in flight. It uses that count, together with a one-bit flag for an in-flight synchronization, to decide cycle by cycle whether the request at the head of the stream may pass. Issue happens in the same cycle as acceptance, so the block adds no storage on the request path.

Top module: `fence_gate`

## Requirements
- R1: After reset no data access is in flight and no synchronization is in flight. A data request offered in the first cycle after reset is accepted when memory is ready.
- R2: An accepted request appears on the issue port in the same cycle, with its id and class unchanged. `iss_sync` is 1 for synchronization and 0 for data.
- R3: The class tag `req_sync` selects the handling: 0 means data and 1 means synchronization. A completion is classified the same way by `cpl_sync`.
- R4: A synchronization request is not accepted while any earlier data access is still in flight. It is accepted in the first cycle in which the registered in-flight count is zero.
- R5: While a synchronization is in flight, no data request is accepted, including in the cycle its completion arrives. Data is accepted again from the following cycle.
- R6: At most one synchronization is in flight. A second synchronization waits for the first one's completion, and it may issue in the cycle after that completion.
- R7: Between fences, data requests are accepted in consecutive cycles, and their completions may return in any order.
- R8: With a count width W, at most 2^W-1 data accesses are in flight. A data request offered at that level is refused, even when a completion arrives in the same cycle.
- R9: A data issue and a data completion in the same cycle leave the in-flight count unchanged.
- R10: When memory deasserts `iss_ready`, `req_ready` is low and the request is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered by the core |
| req_sync | input | 1 | Request class: 1 synchronization, 0 data |
| req_id | input | ID_W | Request tag |
| req_ready | output | 1 | Request accepted this cycle when valid |
| iss_valid | output | 1 | Issue offered to memory |
| iss_sync | output | 1 | Class of the issued operation |
| iss_id | output | ID_W | Tag of the issued operation |
| iss_ready | input | 1 | Memory accepts an issue |
| cpl_valid | input | 1 | An operation has completed |
| cpl_sync | input | 1 | Class of the completed operation |

## Verification
The assertions assume that memory never returns more than it was given. A data completion comes only while the count is nonzero, and a synchronization completion comes only while the pending flag is set. The assertions on the counter and the flag check exactly this. The bench keeps a model of the count and the flag and lets the memory side complete an operation only when the model shows one of that class in flight. This covers both the directed steps and a long pseudo-random sweep, which mixes backpressure, both classes and out-of-order data returns.

// File: rtl/fence_pkg.sv
package fence_pkg;

  typedef enum logic {
    OP_DATA = 1'b0,
    OP_SYNC = 1'b1
  } op_class_e;

  // next in-flight count given one optional issue and one optional return
  function automatic int unsigned count_step(int unsigned cur, logic up, logic down);
    int unsigned nxt;
    nxt = cur;
    if (up)   nxt = nxt + 1;
    if (down) nxt = nxt - 1;
    return nxt;
  endfunction

  // whether a request of the given class may pass this cycle
  function automatic logic may_issue(op_class_e cls, logic pend, logic empty, logic full);
    if (pend) return 1'b0;
    if (cls == OP_SYNC) return empty;
    return !full;
  endfunction

endpackage

// File: rtl/fence_outstanding_ctr.sv
module fence_outstanding_ctr #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic empty,
  output logic full
);
  import fence_pkg::*;

  localparam int unsigned MAX_CNT = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb cnt_d = CNT_W'(count_step(32'(cnt_q), inc, dec));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(MAX_CNT));

  // R8: the gate never issues data into a full counter
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !full);
  // input assumption: memory returns data only when some is in flight
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !empty);
  // R9: simultaneous issue and return keep the count
  assert_net_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt_q));
  // R7: an issue alone makes the counter leave empty
  assert_inc_leaves_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> !empty);

endmodule

// File: rtl/fence_sync_tracker.sv
module fence_sync_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pending
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (set) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  assign pending = pend_q;

  // R6: a fence never issues while another is in flight
  assert_single_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set |-> !pending);
  // R5: an issued fence is marked in flight from the next cycle
  assert_set_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pending);
  // input assumption: a fence completion comes only for an in-flight fence
  assert_clr_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> pending);

endmodule

// File: rtl/fence_issue_gate.sv
module fence_issue_gate #(
  parameter int ID_W = 8
) (
  input  logic            req_valid,
  input  logic            req_sync,
  input  logic [ID_W-1:0] req_id,
  input  logic            iss_ready,
  input  logic            pending,
  input  logic            cnt_empty,
  input  logic            cnt_full,
  output logic            req_ready,
  output logic            iss_valid,
  output logic            iss_sync,
  output logic [ID_W-1:0] iss_id,
  output logic            data_fire,
  output logic            sync_fire
);
  import fence_pkg::*;

  op_class_e cls;
  logic      open;
  logic      fire;

  always_comb begin
    cls       = req_sync ? OP_SYNC : OP_DATA;
    open      = may_issue(cls, pending, cnt_empty, cnt_full);
    req_ready = open && iss_ready;
    iss_valid = open && req_valid;
    iss_sync  = req_sync;
    iss_id    = req_id;
    fire      = req_valid && req_ready;
    data_fire = fire && (cls == OP_DATA);
    sync_fire = fire && (cls == OP_SYNC);
  end

endmodule

// File: rtl/fence_gate.sv
module fence_gate #(
  parameter int ID_W  = 8,
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_sync,
  input  logic [ID_W-1:0] req_id,
  output logic            req_ready,
  output logic            iss_valid,
  output logic            iss_sync,
  output logic [ID_W-1:0] iss_id,
  input  logic            iss_ready,
  input  logic            cpl_valid,
  input  logic            cpl_sync
);

  // named internal events
  logic data_fire;
  logic sync_fire;
  logic data_done;
  logic sync_done;
  logic cnt_empty;
  logic cnt_full;
  logic sync_pending;

  assign data_done = cpl_valid && !cpl_sync;
  assign sync_done = cpl_valid &&  cpl_sync;

  fence_issue_gate #(.ID_W(ID_W)) u_gate (
    .req_valid (req_valid),
    .req_sync  (req_sync),
    .req_id    (req_id),
    .iss_ready (iss_ready),
    .pending   (sync_pending),
    .cnt_empty (cnt_empty),
    .cnt_full  (cnt_full),
    .req_ready (req_ready),
    .iss_valid (iss_valid),
    .iss_sync  (iss_sync),
    .iss_id    (iss_id),
    .data_fire (data_fire),
    .sync_fire (sync_fire)
  );

  fence_outstanding_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (data_fire),
    .dec   (data_done),
    .empty (cnt_empty),
    .full  (cnt_full)
  );

  fence_sync_tracker u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (sync_fire),
    .clr     (sync_done),
    .pending (sync_pending)
  );

  // R4: a fence issues only with nothing in flight
  assert_sync_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fire |-> cnt_empty);
  // R5: no data passes an in-flight fence
  assert_no_data_behind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pending |-> !data_fire);
  // R10: memory backpressure blocks acceptance
  assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |-> !req_ready);
  // R2: an accepted request is offered to memory in the same cycle
  assert_same_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (iss_valid && iss_ready));

endmodule

// File: tb/sim_fence_gate.sv
module sim_fence_gate;
  localparam int P     = 10;
  localparam int ID_W  = 4;
  localparam int CNT_W = 2;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_sync = 1'b0, iss_ready = 1'b0;
  logic cpl_valid = 1'b0, cpl_sync = 1'b0;
  logic [ID_W-1:0] req_id = '0;
  logic req_ready, iss_valid, iss_sync;
  logic [ID_W-1:0] iss_id;

  int n_chk = 0;
  int n_err = 0;
  int m_cnt = 0;
  bit m_pend = 1'b0;
  bit done = 1'b0;

  always #(P/2) clk = ~clk;

  fence_gate #(.ID_W(ID_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_sync(req_sync), .req_id(req_id), .req_ready(req_ready),
    .iss_valid(iss_valid), .iss_sync(iss_sync), .iss_id(iss_id), .iss_ready(iss_ready),
    .cpl_valid(cpl_valid), .cpl_sync(cpl_sync)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, compare before the rising edge
  task automatic step(input logic v, input logic s, input logic [ID_W-1:0] id,
                      input logic ir, input logic cv, input logic cs, input string tag);
    bit open, rdy;
    @(negedge clk);
    req_valid = v; req_sync = s; req_id = id; iss_ready = ir;
    cpl_valid = cv; cpl_sync = cs;
    #(P/4);
    open = !m_pend && (s ? (m_cnt == 0) : (m_cnt != MAXC));
    rdy  = ir && open;
    chk(8'(req_ready), 8'(rdy), {tag, " ready"});
    chk(8'(iss_valid), 8'(v && open), {tag, " iss_valid"});
    if (v && rdy) begin
      chk(8'(iss_sync), 8'(s), {tag, " R3 class"});
      chk(8'(iss_id), 8'(id), {tag, " R2 id"});
    end
    if (v && rdy && !s) m_cnt++;
    if (cv && !cs)      m_cnt--;
    if (v && rdy && s)  m_pend = 1'b1;
    if (cv && cs)       m_pend = 1'b0;
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    #(P/4);
    chk(8'(iss_valid), 8'd0, "R1 idle in reset");
    @(negedge clk);
    rst_n = 1'b1;

    step(1, 0, 4'd1, 1, 0, 0, "R1 first data");
    step(1, 0, 4'd2, 0, 0, 0, "R10 memory stall");
    step(1, 0, 4'd2, 1, 0, 0, "R7 back to back");
    step(1, 0, 4'd3, 1, 0, 0, "R7 back to back");
    step(1, 0, 4'd4, 1, 0, 0, "R8 full stall");
    step(1, 0, 4'd4, 1, 1, 0, "R8 full with return");
    step(1, 0, 4'd4, 1, 1, 0, "R9 issue and return");
    step(1, 0, 4'd5, 1, 0, 0, "R2 pass through");
    step(1, 0, 4'd6, 1, 0, 0, "R9 count held");
    step(1, 1, 4'd7, 1, 1, 0, "R4 sync waits");
    step(1, 1, 4'd7, 1, 1, 0, "R4 sync waits");
    step(1, 1, 4'd7, 1, 1, 0, "R4 last return");
    step(1, 1, 4'd7, 1, 0, 0, "R4 sync after drain");
    step(1, 0, 4'd8, 1, 0, 0, "R5 data behind sync");
    step(1, 1, 4'd9, 1, 0, 0, "R6 second sync");
    step(1, 0, 4'd8, 1, 1, 1, "R5 completion cycle");
    step(1, 0, 4'd8, 1, 0, 0, "R5 data after sync");
    step(1, 1, 4'd9, 1, 1, 0, "R4 sync waits");
    step(1, 1, 4'd9, 1, 0, 0, "R6 next sync");
    step(0, 0, 4'd0, 1, 1, 1, "R6 sync return");
    step(1, 1, 4'd10, 1, 0, 0, "R6 back to back sync");
    step(0, 0, 4'd0, 1, 1, 1, "R6 sync return");

    // pseudo-random sweep with only legal completions
    for (int i = 0; i < 3000; i++) begin
      logic v, s, ir, cv, cs;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      v  = lf[0] | lf[5];
      s  = (lf[3:1] == 3'b000);
      ir = lf[4] | lf[7];
      cs = m_pend;
      cv = m_pend ? lf[6] : ((m_cnt > 0) && lf[8]);
      step(v, s, 4'(lf[12:9]), ir, cv, cs, "R7 sweep");
    end

    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(P * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule